// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock

This block is a memory-mapped seconds clock. A tick-enable input, pulsed once per oscillator period, is counted against a programmable tick count. Each time the count is reached a one-second event fires. An optional fractional correction lengthens some seconds by one tick, so that a non-integer oscillator frequency averages out over a sixteen-second cycle. A 32-bit seconds counter advances on each event. A new time can be staged by software and is loaded only at the next event.

Two interrupt sources are provided: one for every second and one for an alarm compare. Each has a sticky status flag that is cleared by writing 1. Each also has a mask bit, set through one offset and cleared through another. The single interrupt output is high while any flagged source is also enabled. Two control flags are kept as plain storage for the surrounding power logic. Everything runs on one clock.

Top module: `calSecondsRtc`

## Requirements
- R1: After reset the calibration register reads 0x198233, current time reads 0, the tick counter reads 0, the mask reads 0, and the interrupt output is low.
- R2: With calibration bit 20 clear, every second lasts exactly N tick-enable pulses, where N is calibration bits 15:0. Bits 19:16 have no effect in this case.
- R3: With calibration bit 20 set and F in bits 19:16, seconds are numbered k = 0,1,2,... from the last calibration write. Second k lasts N+1 pulses when (k mod 16) < F and N pulses otherwise.
- R4: Any write to the calibration write offset (0x08) sets the tick counter to zero. The next second event then comes exactly one full period later. The stored word reads back at 0x0C.
- R5: A write to the set-time offset (0x00) can be read back at 0x04 at once. Current time (0x10) keeps its value until the next second event, which loads the written value.
- R6: On a second event with no staged time, current time increases by exactly one.
- R7: Status bit 0 (offset 0x20) sets on every second event. Status bit 1 sets on a second event whose resulting time equals the alarm register (0x18). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: Writing 1 to a bit at 0x28 enables that source, and writing 1 at 0x2C disables it. Offset 0x24 reads the enable bits, and a write there is ignored. The interrupt output is high exactly while some status bit and its enable bit are both 1.
- R9: The control register (0x40) stores bits 31 and 24 as read/write flags. All its other bits read 0.
- R10: Offset 0x14 returns the live tick counter, which holds its value while tick-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One pulse per oscillator tick |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the fractional correction crossing its sixteen-second boundary. Only there does a wrong phase counter or a wrong comparison show up as a stretched or missing tick. The bench programs small tick counts so that a full cycle of seventeen or eighteen seconds fits in a few hundred clocks. It measures the length of every second by polling current time after each edge. A similar difficulty applies to an alarm that must fire on the event that loads a staged time. The bench stages a time one below the alarm value and then watches the status across two consecutive events.

// File: rtl/calRtcPkg.sv
package calRtcPkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int TIME_W  = 32;
  localparam int TICK_W  = 16;
  localparam int FRAC_W  = 4;
  localparam int CAL_W   = TICK_W + FRAC_W + 1;
  localparam int NUM_IRQ = 2;
  localparam int BATT_BIT = 31;
  localparam int OSC_BIT  = 24;
  localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;

  localparam logic [ADDR_W-1:0] OFF_SETW  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SETR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CALW  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CALR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TIME  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_TICK  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ALARM = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_STS   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_EN    = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_DIS   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h40;

  typedef struct packed {
    logic               setTimeWr;
    logic               calibWr;
    logic               alarmWr;
    logic               ctrlWr;
    logic [NUM_IRQ-1:0] stsClr;
    logic [NUM_IRQ-1:0] maskSet;
    logic [NUM_IRQ-1:0] maskClr;
    logic [BUS_W-1:0]   data;
  } rtcStrobe_t;

  typedef struct packed {
    logic [TIME_W-1:0]  setTime;
    logic [TIME_W-1:0]  curTime;
    logic [TIME_W-1:0]  alarm;
    logic [CAL_W-1:0]   calib;
    logic [TICK_W-1:0]  tick;
    logic [NUM_IRQ-1:0] status;
    logic [NUM_IRQ-1:0] mask;
    logic               battEn;
    logic               oscEn;
  } rtcView_t;
endpackage

// File: rtl/calRtcCtrl.sv
module calRtcCtrl
  import calRtcPkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  rtcView_t          view,
  output rtcStrobe_t        stb,
  output logic [BUS_W-1:0]  rdData
);
  always_comb begin
    stb           = '0;
    stb.data      = wrData;
    stb.setTimeWr = wrEn && (addr == OFF_SETW);
    stb.calibWr   = wrEn && (addr == OFF_CALW);
    stb.alarmWr   = wrEn && (addr == OFF_ALARM);
    stb.ctrlWr    = wrEn && (addr == OFF_CTRL);
    stb.stsClr    = (wrEn && (addr == OFF_STS)) ? wrData[NUM_IRQ-1:0] : '0;
    stb.maskSet   = (wrEn && (addr == OFF_EN))  ? wrData[NUM_IRQ-1:0] : '0;
    stb.maskClr   = (wrEn && (addr == OFF_DIS)) ? wrData[NUM_IRQ-1:0] : '0;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      OFF_SETR:  rdData = BUS_W'(view.setTime);
      OFF_CALR:  rdData = BUS_W'(view.calib);
      OFF_TIME:  rdData = BUS_W'(view.curTime);
      OFF_TICK:  rdData = BUS_W'(view.tick);
      OFF_ALARM: rdData = BUS_W'(view.alarm);
      OFF_STS:   rdData = BUS_W'(view.status);
      OFF_MASK:  rdData = BUS_W'(view.mask);
      OFF_CTRL: begin
        rdData[BATT_BIT] = view.battEn;
        rdData[OSC_BIT]  = view.oscEn;
      end
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/calRtcDatapath.sv
module calRtcDatapath
  import calRtcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  rtcStrobe_t stb,
  output rtcView_t   view,
  output logic       irq
);
  localparam int LIM_W = TICK_W + 1;

  logic [TICK_W-1:0]  tickCnt;
  logic [FRAC_W-1:0]  fracCnt;
  logic [CAL_W-1:0]   calib;
  logic [TIME_W-1:0]  curTime, setTime, alarm, nextTime;
  logic               pending, battEn, oscEn, stretch, secEvent;
  logic [LIM_W-1:0]   limit;
  logic [NUM_IRQ-1:0] srcHit, status, mask;
  logic               unusedData;

  assign unusedData = ^{stb.data[BUS_W-1:CAL_W]};

  // Period of the current second, stretched by one while the phase is below F
  assign stretch  = calib[CAL_W-1] && (fracCnt < calib[TICK_W +: FRAC_W]);
  assign limit    = {1'b0, calib[TICK_W-1:0]} + LIM_W'(stretch);
  assign secEvent = tickEn && !stb.calibWr &&
                    (({1'b0, tickCnt} + LIM_W'(1)) == limit);
  assign nextTime = pending ? setTime : curTime + TIME_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      fracCnt <= '0;
    end else if (stb.calibWr) begin
      tickCnt <= '0;
      fracCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= secEvent ? '0 : tickCnt + TICK_W'(1);
      if (secEvent) fracCnt <= fracCnt + FRAC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime <= '0;
      setTime <= '0;
      pending <= 1'b0;
      alarm   <= '0;
      calib   <= CAL_RESET;
      battEn  <= 1'b0;
      oscEn   <= 1'b0;
    end else begin
      if (secEvent) begin
        curTime <= nextTime;
        pending <= 1'b0;
      end
      if (stb.setTimeWr) begin
        setTime <= stb.data[TIME_W-1:0];
        pending <= 1'b1;
      end
      if (stb.alarmWr) alarm <= stb.data[TIME_W-1:0];
      if (stb.calibWr) calib <= stb.data[CAL_W-1:0];
      if (stb.ctrlWr) begin
        battEn <= stb.data[BATT_BIT];
        oscEn  <= stb.data[OSC_BIT];
      end
    end
  end

  assign srcHit[0] = secEvent;
  assign srcHit[1] = secEvent && (nextTime == alarm);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irqSrc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        status[i] <= 1'b0;
        mask[i]   <= 1'b0;
      end else begin
        if (srcHit[i])          status[i] <= 1'b1;
        else if (stb.stsClr[i]) status[i] <= 1'b0;
        if (stb.maskSet[i])      mask[i] <= 1'b1;
        else if (stb.maskClr[i]) mask[i] <= 1'b0;
      end
    end
  end

  assign irq = |(status & mask);

  always_comb begin
    view         = '0;
    view.setTime = setTime;
    view.curTime = curTime;
    view.alarm   = alarm;
    view.calib   = calib;
    view.tick    = tickCnt;
    view.status  = status;
    view.mask    = mask;
    view.battEn  = battEn;
    view.oscEn   = oscEn;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (limit != '0) |-> ({1'b0, tickCnt} < limit)); // R2
  AST_CALIB_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.calibWr |=> (tickCnt == '0)); // R4
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !secEvent |=> (curTime == $past(curTime))); // R5
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (secEvent && pending) |=> (curTime == $past(setTime))); // R5
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (secEvent && !pending) |=> (curTime == $past(curTime) + TIME_W'(1))); // R6
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stsClr[0] && !secEvent) |=> !status[0]); // R7
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskClr[1] && !stb.maskSet[1]) |=> !mask[1]); // R8
endmodule

// File: rtl/calSecondsRtc.sv
module calSecondsRtc
  import calRtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq
);
  rtcStrobe_t stb;
  rtcView_t   view;

  calRtcCtrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .view   (view),
    .stb    (stb),
    .rdData (rdData)
  );

  calRtcDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .stb    (stb),
    .view   (view),
    .irq    (irq)
  );
endmodule

// File: tb/tb_calSecondsRtc.sv
module tb_calSecondsRtc;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam logic [20:0] CAL_TAB [0:NVEC-1] =
    '{21'h000005, 21'h000008, 21'h130006, 21'h0F0004, 21'h1F0003};
  localparam int SEC_TAB [0:NVEC-1] = '{3, 3, 18, 4, 17};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  calSecondsRtc dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [31:0] exp,
                           input string req);
    logic [31:0] v;
    busRead(a, v);
    check(v == exp, req, v, exp);
  endtask

  // Counts edges until current time changes; returns edge count and new time
  task automatic measure(output int cnt, output logic [31:0] newT);
    logic [31:0] t0, t;
    busRead(8'h10, t0);
    cnt = 0;
    do begin
      step(1);
      cnt++;
      busRead(8'h10, t);
    end while (t == t0 && cnt < 70000);
    newT = t;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [31:0] t, tPrev, v;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectReg(8'h0C, 32'h00198233, "R1 calib reset");
    expectReg(8'h10, 32'h0, "R1 time reset");
    expectReg(8'h14, 32'h0, "R1 tick reset");
    expectReg(8'h24, 32'h0, "R1 mask reset");
    check(irq == 1'b0, "R1 irq reset", 32'(irq), 32'h0);
    tickEn = 1'b1;

    // Table walk: second lengths for plain and fractional calibrations (R2, R3, R6)
    for (int i = 0; i < NVEC; i++) begin
      busWrite(8'h08, 32'(CAL_TAB[i]));
      expectReg(8'h0C, 32'(CAL_TAB[i]), "R4 calib readback");
      busRead(8'h10, tPrev);
      for (int s = 0; s < SEC_TAB[i]; s++) begin
        int expP;
        expP = int'(CAL_TAB[i][15:0]);
        if (CAL_TAB[i][20] && ((s % 16) < int'(CAL_TAB[i][19:16]))) expP++;
        measure(cnt, t);
        check(cnt == expP, CAL_TAB[i][20] ? "R3 fractional period" : "R2 period",
              32'(cnt), 32'(expP));
        check(t == tPrev + 1, "R6 time step", t, tPrev + 1);
        tPrev = t;
      end
    end

    // R10 live tick counter, frozen while tickEn low
    busWrite(8'h08, 32'd100);
    step(7);
    expectReg(8'h14, 32'd7, "R10 tick live");
    tickEn = 1'b0;
    step(5);
    expectReg(8'h14, 32'd7, "R10 tick hold");
    tickEn = 1'b1;

    // R4 calibration write mid-second restarts the period
    busWrite(8'h08, 32'd10);
    step(6);
    busWrite(8'h08, 32'd10);
    measure(cnt, t);
    check(cnt == 10, "R4 restart period", 32'(cnt), 32'd10);

    // R5 staged time
    busWrite(8'h08, 32'd10);
    busRead(8'h10, tPrev);
    busWrite(8'h00, 32'h1234);
    expectReg(8'h04, 32'h1234, "R5 set-time readback");
    expectReg(8'h10, tPrev, "R5 time not yet loaded");
    step(8);
    expectReg(8'h10, tPrev, "R5 time held before event");
    step(1);
    expectReg(8'h10, 32'h1234, "R5 time loaded at event");
    step(10);
    expectReg(8'h10, 32'h1235, "R6 step after load");

    // R7, R8 alarm, status and mask
    busWrite(8'h08, 32'd8);       // E0
    busWrite(8'h00, 32'h50);      // E1
    busWrite(8'h18, 32'h51);      // E2
    busWrite(8'h20, 32'h3);       // E3
    step(5);                      // after E8
    expectReg(8'h20, 32'h1, "R7 sec flag only");
    expectReg(8'h10, 32'h50, "R5 staged load");
    step(8);                      // after E16
    expectReg(8'h20, 32'h3, "R7 alarm flag");
    check(irq == 1'b0, "R8 masked irq", 32'(irq), 32'h0);
    busWrite(8'h28, 32'h2);       // E17
    check(irq == 1'b1, "R8 enabled irq", 32'(irq), 32'h1);
    expectReg(8'h24, 32'h2, "R8 mask read");
    busWrite(8'h20, 32'h1);       // E18
    busWrite(8'h20, 32'h0);       // E19
    expectReg(8'h20, 32'h2, "R7 w1c selective, write 0 no effect");
    check(irq == 1'b1, "R8 irq from alarm", 32'(irq), 32'h1);
    busWrite(8'h2C, 32'h2);       // E20
    check(irq == 1'b0, "R8 disabled irq", 32'(irq), 32'h0);
    expectReg(8'h24, 32'h0, "R8 mask after disable");
    busWrite(8'h20, 32'h2);       // E21
    expectReg(8'h20, 32'h0, "R7 alarm cleared");
    busWrite(8'h28, 32'h1);       // E22
    step(1);                      // after E23
    check(irq == 1'b0, "R8 irq before sec", 32'(irq), 32'h0);
    step(1);                      // after E24
    check(irq == 1'b1, "R8 irq on sec", 32'(irq), 32'h1);
    expectReg(8'h20, 32'h1, "R7 no alarm on mismatch");
    busWrite(8'h24, 32'h3);
    expectReg(8'h24, 32'h1, "R8 mask offset write ignored");

    // R9 control storage
    busWrite(8'h40, 32'hFFFF_FFFF);
    busRead(8'h40, v);
    check(v == 32'h8100_0000, "R9 control set", v, 32'h8100_0000);
    busWrite(8'h40, 32'h0);
    expectReg(8'h40, 32'h0, "R9 control clear");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule